// File: doc/BRIEF.md
# Register Rename Map with Free List

This block renames architectural registers onto a larger physical register pool for an out-of-order core. It holds a table that gives, for every logical register, the physical register currently bound to it. A circular queue holds the indices of physical registers that are not bound to anything. When an instruction with a destination is dispatched, the block takes the oldest free index, binds the destination to it, and hands back both the new index and the index the destination was bound to before. The caller stores that previous index with the instruction. When the instruction retires, the caller returns the previous index on the release port, and that index goes to the tail of the queue. Source operands are translated through the table on combinational lookup ports.

The allocate port is a valid/ready stream. `alloc_ready` is high whenever at least one physical register is free. An allocation takes place only in a cycle where `alloc_valid` and `alloc_ready` are both high. A caller that sees `alloc_ready` low must hold its request, and dispatch stalls until a release brings the count back above zero. A release issued in the same cycle does not make an index available to an allocation in that cycle. The release port is a plain strobe with no back-pressure: retirement can never return more indices than were taken, so the queue cannot overflow. `free_count` lets dispatch plan ahead, for example to stall a whole group before it is short of registers.

Top module: `rename_map_unit`

## Requirements
- R1: After reset, logical register i maps to physical register i for every i, so a source lookup of i returns i.
- R2: After reset, `free_count` equals NUM_PHYS - NUM_LOG (32 with defaults), and successive allocations return the physical indices NUM_LOG, NUM_LOG+1, ... in ascending order.
- R3: `alloc_ready` is 1 exactly when `free_count` is non-zero. In a cycle where `alloc_valid` and `alloc_ready` are both 1, `alloc_preg` is the oldest free index, and from the next cycle on the table maps `alloc_lreg` to that index.
- R4: In every cycle, `alloc_old_preg` shows the physical register that `alloc_lreg` maps to at the start of that cycle. In an accepted allocation it never equals `alloc_preg`.
- R5: An index returned with `rel_valid` is appended behind all indices already free, and is handed out again in first-in, first-out order.
- R6: At each clock edge `free_count` changes by +1 for a release, by -1 for an accepted allocation, and by 0 when both happen in the same cycle. No index is lost or duplicated.
- R7: While `free_count` is 0, `alloc_valid` has no effect: the table is unchanged and the count does not decrease.
- R8: Source lookups and `alloc_old_preg` reflect the table as it was at the start of the cycle. An allocation becomes visible on the lookup ports from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Destination allocation request |
| alloc_ready | output | 1 | A free physical register is available |
| alloc_lreg | input | 5 | Logical destination to rename |
| alloc_preg | output | 6 | Physical register granted |
| alloc_old_preg | output | 6 | Previous mapping of alloc_lreg |
| src_lreg | input | NUM_SRC*5 (10) | Packed logical source indices, port k at bits [5k+4:5k] |
| src_preg | output | NUM_SRC*6 (12) | Packed translated sources, port k at bits [6k+5:6k] |
| rel_valid | input | 1 | Retirement returns a physical register |
| rel_preg | input | 6 | Physical register index being returned |
| free_count | output | 7 | Number of free physical registers |

## Verification
The bench builds the block with its default sizes (32 logical, 64 physical, two source ports). Because of this, the free queue starts with 32 entries, and phases of bursty allocation can drain it to zero within a few dozen cycles. This brings the empty stall, allocate-with-release at zero and one, and pointer wrap past index 63 all within reach of a short random run. Directed steps pin down the reset mapping, the ascending initial grants and a simultaneous allocate and release. A bench model of the table and queue predicts every output.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned DEF_NUM_LOG  = 32;
  localparam int unsigned DEF_NUM_PHYS = 64;
  localparam int unsigned DEF_NUM_SRC  = 2;

  // wrap-around increment for a circular pointer of arbitrary depth
  function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/rn_free_fifo.sv
module rn_free_fifo #(
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned INIT_COUNT = 32,
  parameter int unsigned INIT_BASE  = 32,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          push,
  input  logic [IW-1:0] push_idx,
  output logic [IW-1:0] head_idx,
  output logic [CW-1:0] count,
  output logic          empty
);
  import rn_pkg::*;

  logic [IW-1:0] slot_q [DEPTH];
  logic [IW-1:0] rd_ptr_q, wr_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          pop_ok;

  assign empty    = (cnt_q == '0);
  assign pop_ok   = pop && !empty;
  assign head_idx = slot_q[rd_ptr_q];
  assign count    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        slot_q[i] <= (i < INIT_COUNT) ? IW'(INIT_BASE + i) : '0;
    end else if (push) begin
      slot_q[wr_ptr_q] <= push_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= IW'(INIT_COUNT % DEPTH);
      cnt_q    <= CW'(INIT_COUNT);
    end else begin
      if (pop_ok) rd_ptr_q <= IW'(wrap_inc(rd_ptr_q, DEPTH));
      if (push)   wr_ptr_q <= IW'(wrap_inc(wr_ptr_q, DEPTH));
      case ({push, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop_ok) |-> (cnt_q < CW'(DEPTH))); // R6

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push != pop_ok) |=> (cnt_q != $past(cnt_q))); // R6

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push == pop_ok) |=> $stable(cnt_q)); // R6

  AST_EMPTY_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> (cnt_q <= 1)); // R7
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int unsigned NUM_LOG  = 32,
  parameter int unsigned NUM_PHYS = 64,
  parameter int unsigned NUM_SRC  = 2,
  localparam int unsigned LW = $clog2(NUM_LOG),
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [LW-1:0]         wr_lreg,
  input  logic [PW-1:0]         wr_preg,
  output logic [PW-1:0]         old_preg,
  input  logic [NUM_SRC*LW-1:0] rd_lreg,
  output logic [NUM_SRC*PW-1:0] rd_preg
);
  logic [PW-1:0] bind_q [NUM_LOG];

  for (genvar g = 0; g < NUM_LOG; g++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                bind_q[g] <= PW'(g);
      else if (wr_en && wr_lreg == LW'(g))       bind_q[g] <= wr_preg;
    end

    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_lreg == LW'(g)) |=> $stable(bind_q[g])); // R7
  end

  assign old_preg = bind_q[wr_lreg];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign rd_preg[s*PW +: PW] = bind_q[rd_lreg[s*LW +: LW]];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (bind_q[$past(wr_lreg)] == $past(wr_preg))); // R3
endmodule

// File: rtl/rename_map_unit.sv
module rename_map_unit #(
  parameter int unsigned NUM_LOG  = rn_pkg::DEF_NUM_LOG,
  parameter int unsigned NUM_PHYS = rn_pkg::DEF_NUM_PHYS,
  parameter int unsigned NUM_SRC  = rn_pkg::DEF_NUM_SRC,
  localparam int unsigned LW = $clog2(NUM_LOG),
  localparam int unsigned PW = $clog2(NUM_PHYS),
  localparam int unsigned CW = $clog2(NUM_PHYS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_valid,
  output logic                  alloc_ready,
  input  logic [LW-1:0]         alloc_lreg,
  output logic [PW-1:0]         alloc_preg,
  output logic [PW-1:0]         alloc_old_preg,
  input  logic [NUM_SRC*LW-1:0] src_lreg,
  output logic [NUM_SRC*PW-1:0] src_preg,
  input  logic                  rel_valid,
  input  logic [PW-1:0]         rel_preg,
  output logic [CW-1:0]         free_count
);
  logic fl_empty;
  logic grant;

  assign alloc_ready = !fl_empty;
  assign grant       = alloc_valid && alloc_ready;

  rn_free_fifo #(
    .DEPTH      (NUM_PHYS),
    .INIT_COUNT (NUM_PHYS - NUM_LOG),
    .INIT_BASE  (NUM_LOG)
  ) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop      (grant),
    .push     (rel_valid),
    .push_idx (rel_preg),
    .head_idx (alloc_preg),
    .count    (free_count),
    .empty    (fl_empty)
  );

  rn_map_table #(
    .NUM_LOG  (NUM_LOG),
    .NUM_PHYS (NUM_PHYS),
    .NUM_SRC  (NUM_SRC)
  ) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (grant),
    .wr_lreg  (alloc_lreg),
    .wr_preg  (alloc_preg),
    .old_preg (alloc_old_preg),
    .rd_lreg  (src_lreg),
    .rd_preg  (src_preg)
  );

  AST_FRESH_PREG: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (alloc_preg != alloc_old_preg)); // R4

  AST_READY_MATCHES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ready == (free_count != '0)); // R3
endmodule

// File: tb/tb_rename_map_unit.sv
module tb_rename_map_unit;
  localparam int NL = 32, NP = 64, NS = 2, LW = 5, PW = 6, CW = 7;

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, rel_valid = 0;
  logic [LW-1:0] alloc_lreg = '0;
  logic [NS*LW-1:0] src_lreg = '0;
  logic [PW-1:0] rel_preg = '0;
  logic alloc_ready;
  logic [PW-1:0] alloc_preg, alloc_old_preg;
  logic [NS*PW-1:0] src_preg;
  logic [CW-1:0] free_count;

  always #4 clk = ~clk; // 125 MHz

  rename_map_unit dut (.*);

  int n_cmp = 0, n_bad = 0;
  int mmap [NL];
  int mfree [$];
  int pend [$];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit will_grant();
    return alloc_valid && (mfree.size() != 0);
  endfunction

  // drive at negedge, compare before posedge, advance model at posedge
  task automatic step(input bit av, input int lr, input bit rv, input int s0, input int s1);
    bit g;
    int gp, op;
    @(negedge clk);
    alloc_valid = av; alloc_lreg = LW'(lr);
    rel_valid = rv && (pend.size() != 0);
    rel_preg = rel_valid ? PW'(pend[0]) : '0;
    src_lreg = {LW'(s1), LW'(s0)};
    #2;
    g = will_grant();
    chk(free_count == CW'(mfree.size()), "R6 free_count", free_count, mfree.size());
    chk(alloc_ready == (mfree.size() != 0), "R3 alloc_ready", alloc_ready, mfree.size() != 0);
    chk(alloc_old_preg == PW'(mmap[lr]), "R4 old_preg", alloc_old_preg, mmap[lr]);
    chk(src_preg[PW-1:0] == PW'(mmap[s0]), "R8 src0", src_preg[PW-1:0], mmap[s0]);
    chk(src_preg[2*PW-1:PW] == PW'(mmap[s1]), "R8 src1", src_preg[2*PW-1:PW], mmap[s1]);
    if (g) chk(alloc_preg == PW'(mfree[0]), "R5 alloc_preg", alloc_preg, mfree[0]);
    @(posedge clk);
    if (g) begin
      gp = mfree.pop_front();
      op = mmap[lr];
      mmap[lr] = gp;
      pend.push_back(op);
    end
    if (rel_valid) mfree.push_back(pend.pop_front());
  endtask

  initial begin
    #200000;
    n_bad++; n_cmp++;
    $display("FAIL watchdog actual=0 expected=1");
    if (!done) begin
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NL; i++) mmap[i] = i;
    for (int i = NL; i < NP; i++) mfree.push_back(i);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1 reset identity map, R2 reset count
    chk(free_count == CW'(NP - NL), "R2 reset count", free_count, NP - NL);
    for (int i = 0; i < NL; i += 2) begin
      @(negedge clk); src_lreg = {LW'(i + 1), LW'(i)}; #1;
      chk(src_preg[PW-1:0] == PW'(i), "R1 reset map", src_preg[PW-1:0], i);
      chk(src_preg[2*PW-1:PW] == PW'(i + 1), "R1 reset map", src_preg[2*PW-1:PW], i + 1);
    end
    // R2 ascending first grants
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); alloc_valid = 1; alloc_lreg = LW'(k); #1;
      chk(alloc_preg == PW'(NL + k), "R2 initial order", alloc_preg, NL + k);
      @(negedge clk); alloc_valid = 0;
      // reproduce into model
      void'(mfree.pop_front()); pend.push_back(mmap[k]); mmap[k] = NL + k;
    end
    // R8: lookup of written register visible next cycle
    step(0, 0, 0, 0, 3);
    // R7 drain to empty then request while empty
    while (mfree.size() != 0) step(1, $urandom_range(NL - 1), 0, $urandom_range(NL - 1), 0);
    for (int k = 0; k < 3; k++) step(1, 7, 0, 7, 7); // R7 map for 7 must stay
    // R6 alloc+release at zero: no grant, count rises
    step(1, 9, 1, 9, 9);
    // R6 alloc+release at one: count unchanged
    step(1, 10, 1, 10, 9);
    // random mixed phases
    for (int ph = 0; ph < 12; ph++) begin
      int pa = (ph % 3 == 0) ? 90 : (ph % 3 == 1) ? 30 : 60;
      int pr = (ph % 3 == 0) ? 20 : (ph % 3 == 1) ? 90 : 55;
      for (int c = 0; c < 150; c++)
        step($urandom_range(99) < pa, $urandom_range(NL - 1),
             $urandom_range(99) < pr, $urandom_range(NL - 1), $urandom_range(NL - 1));
    end
    // drain pending, final count check
    while (pend.size() != 0) step(0, 0, 1, 0, 1);
    step(0, 0, 0, 2, 3);
    chk(free_count == CW'(NP - NL), "R6 final count", free_count, NP - NL);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule